// File: doc/BRIEF.md
# Frame-Deferred USB Host Interrupt Aggregator

This block gathers the interrupt causes of a USB host controller and turns them into a single registered, level-sensitive interrupt line. There are two kinds of cause. Transaction causes come from the schedule engine as one-cycle pulses. These are completion requests carried by transfer descriptors, short packets, and transaction errors. Controller-error causes report faults in the host controller's own operation.

Transaction causes are first collected in a hidden pending register. They become visible in the status register only when the schedule engine pulses `frame_wb_done`. That pulse means the status of the frame's last completed transaction has been written back to memory. Software can therefore process every finished descriptor of that frame as soon as it sees the interrupt. Each transaction status bit is gated by a software enable bit. Controller-error causes skip both the pending stage and the enable gate. Software clears any status bit by writing a one to it. The interrupt stays high until no enabled transaction bit and no error bit remains set.

Top module: `usb_irq_agg`

## Requirements
- R1: After a synchronous reset, all transaction and error status bits read zero, all enable bits are zero, and `irq` is low.
- R2: A pulse on `xact_evt[i]` does not change `status_xact`. The next `frame_wb_done` pulse sets, after that edge, every status bit whose cause pulsed since the previous pulse. Bit 0 is completion-request, bit 1 is short-packet, and bit 2 is transaction-error.
- R3: A transaction pulse that arrives in the same cycle as `frame_wb_done` belongs to the next frame. It appears in status only at the following `frame_wb_done`.
- R4: A pulse on `err_evt[j]` sets `status_err[j]` after that same clock edge, without waiting for a frame boundary.
- R5: When `clr_we` is high, each one in `clr_xact` or `clr_err` clears the matching status bit after that edge. Zero bits leave their status bits unchanged.
- R6: When a status bit is set and cleared in the same cycle, it ends up set.
- R7: `irq` rises one cycle after some status bit is both set and enabled, or after any error bit is set. It stays high until all of them are cleared, and it falls one cycle after that.
- R8: A transaction status bit whose enable is zero is still latched, but it does not raise `irq`. Error bits raise `irq` whatever the enable value.
- R9: When `en_we` is high, `en_wdata` loads the enable register at that edge. It affects `irq` from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xact_evt | input | N_XACT | Transaction cause pulses |
| err_evt | input | N_ERR | Controller-error cause pulses |
| frame_wb_done | input | 1 | One-cycle pulse: frame's last transaction status written back |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | N_XACT | New enable mask |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_xact | input | N_XACT | Transaction status bits to clear |
| clr_err | input | N_ERR | Error status bits to clear |
| status_xact | output | N_XACT | Visible transaction status |
| status_err | output | N_ERR | Error status |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with N_XACT = 5 and N_ERR = 3. This is wider than the defaults, so enable masking, partial write-one-to-clear patterns, and set-against-clear collisions apply to bits above the three named causes. Several error bits can also be pending at once. Random frames of varying length then test whether pending events fold into the right frame boundary. They also test whether the interrupt holds while any single source stays active.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int XACT_SRC_DEFAULT = 3;
  localparam int ERR_SRC_DEFAULT  = 2;

  // Bit positions of the named transaction causes
  typedef enum int {
    XB_COMPLETE = 0,
    XB_SHORT    = 1,
    XB_XERR     = 2
  } xact_bit_e;
endpackage

// File: rtl/irq_pend_collect.sv
module irq_pend_collect #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         frame_done,
  output logic [W-1:0] pend
);
  logic [W-1:0] pend_q;

  // A frame boundary hands the collected set onward; events in that cycle start the next frame
  always_ff @(posedge clk) begin
    if (rst)             pend_q <= '0;
    else if (frame_done) pend_q <= evt;
    else                 pend_q <= pend_q | evt;
  end

  assign pend = pend_q;

  // R3: coincident events become the whole new pending set
  a_r3_new_frame: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (pend_q == $past(evt)));
  // R2: collected events are never lost between boundaries
  a_r2_accumulate: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> ((pend_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  // Set has priority over clear, bit by bit
  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= (q_r & ~clr) | set;
  end

  assign q = q_r;

  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((q_r & $past(set)) == $past(set)));
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (|clr) |=> ((q_r & $past(clr & ~set)) == '0));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!(|set) && !(|clr)) |=> $stable(q_r));
endmodule

// File: rtl/irq_drive.sv
module irq_drive #(
  parameter int NX = 3,
  parameter int NE = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NX-1:0] sx,
  input  logic [NX-1:0] en,
  input  logic [NE-1:0] se,
  output logic          irq
);
  logic any_xact, any_err, irq_q;

  assign any_xact = |(sx & en);
  assign any_err  = |se;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any_xact | any_err;
  end

  assign irq = irq_q;
endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
  import usb_irq_pkg::*;
#(
  parameter int N_XACT = XACT_SRC_DEFAULT,
  parameter int N_ERR  = ERR_SRC_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_XACT-1:0] xact_evt,
  input  logic [N_ERR-1:0]  err_evt,
  input  logic              frame_wb_done,
  input  logic              en_we,
  input  logic [N_XACT-1:0] en_wdata,
  input  logic              clr_we,
  input  logic [N_XACT-1:0] clr_xact,
  input  logic [N_ERR-1:0]  clr_err,
  output logic [N_XACT-1:0] status_xact,
  output logic [N_ERR-1:0]  status_err,
  output logic              irq
);
  logic [N_XACT-1:0] pend, xact_set, xact_clr, en_q;
  logic [N_ERR-1:0]  err_clr;

  irq_pend_collect #(.W(N_XACT)) u_pend (
    .clk(clk), .rst(rst), .evt(xact_evt), .frame_done(frame_wb_done), .pend(pend)
  );

  assign xact_set = frame_wb_done ? pend : '0;
  assign xact_clr = clr_we ? clr_xact : '0;
  assign err_clr  = clr_we ? clr_err  : '0;

  irq_w1c_bank #(.W(N_XACT)) u_xstat (
    .clk(clk), .rst(rst), .set(xact_set), .clr(xact_clr), .q(status_xact)
  );

  irq_w1c_bank #(.W(N_ERR)) u_estat (
    .clk(clk), .rst(rst), .set(err_evt), .clr(err_clr), .q(status_err)
  );

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  irq_drive #(.NX(N_XACT), .NE(N_ERR)) u_drive (
    .clk(clk), .rst(rst), .sx(status_xact), .en(en_q), .se(status_err), .irq(irq)
  );

  // R2: transaction status bits rise only at a frame boundary
  a_r2_deferred: assert property (@(posedge clk) disable iff (rst)
    !frame_wb_done |=> ((status_xact & ~$past(status_xact)) == '0));
  // R4/R8: error bits raise irq without masking
  a_r4_err_irq: assert property (@(posedge clk) disable iff (rst)
    (|status_err) |=> irq);
  // R7: no active source means irq falls
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (!(|(status_xact & en_q)) && !(|status_err)) |=> !irq);
  // R8: an enabled status bit keeps irq high
  a_r8_enabled: assert property (@(posedge clk) disable iff (rst)
    (|(status_xact & en_q)) |=> irq);
endmodule

// File: tb/test_usb_irq_agg.sv
module test_usb_irq_agg;
  localparam int NX = 5;
  localparam int NE = 3;

  logic clk = 1'b0;
  logic rst;
  logic [NX-1:0] xact_evt, en_wdata, clr_xact, status_xact;
  logic [NE-1:0] err_evt, clr_err, status_err;
  logic frame_wb_done, en_we, clr_we, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  logic [NX-1:0] m_pend, m_sx, m_en;
  logic [NE-1:0] m_se;
  logic m_irq;

  always #5 clk = ~clk;

  usb_irq_agg #(.N_XACT(NX), .N_ERR(NE)) i_usb_irq_agg (
    .clk(clk), .rst(rst), .xact_evt(xact_evt), .err_evt(err_evt),
    .frame_wb_done(frame_wb_done), .en_we(en_we), .en_wdata(en_wdata),
    .clr_we(clr_we), .clr_xact(clr_xact), .clr_err(clr_err),
    .status_xact(status_xact), .status_err(status_err), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NX-1:0] nx_sx(input logic [NX-1:0] sx, pend,
                                          input logic wb, cw, input logic [NX-1:0] cx);
    logic [NX-1:0] c;
    c = cw ? cx : '0;
    return wb ? ((sx & ~c) | pend) : (sx & ~c);
  endfunction

  task automatic idle_inputs();
    xact_evt = '0; err_evt = '0; frame_wb_done = 1'b0;
    en_we = 1'b0; en_wdata = '0; clr_we = 1'b0; clr_xact = '0; clr_err = '0;
  endtask

  // Inputs are set before this call (at a falling edge); advance one edge and compare
  task automatic step(input string tag);
    logic [NX-1:0] n_pend, n_sx, n_en;
    logic [NE-1:0] n_se;
    logic n_irq;
    n_pend = frame_wb_done ? xact_evt : (m_pend | xact_evt);
    n_sx   = nx_sx(m_sx, m_pend, frame_wb_done, clr_we, clr_xact);
    n_se   = (m_se & ~(clr_we ? clr_err : '0)) | err_evt;
    n_en   = en_we ? en_wdata : m_en;
    n_irq  = (|(m_sx & m_en)) | (|m_se);
    @(posedge clk);
    #1;
    m_pend = n_pend; m_sx = n_sx; m_se = n_se; m_en = n_en; m_irq = n_irq;
    chk({tag, " R2 status_xact"}, 32'(status_xact), 32'(m_sx));
    chk({tag, " R4 status_err"}, 32'(status_err), 32'(m_se));
    chk({tag, " R7 irq"}, 32'(irq), 32'(m_irq));
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset status_xact", 32'(status_xact), 0);
    chk("R1 reset status_err", 32'(status_err), 0);
    chk("R1 reset irq", 32'(irq), 0);
    rst = 1'b0;
    m_pend = '0; m_sx = '0; m_se = '0; m_en = '0; m_irq = 1'b0;

    // R2: event stays hidden until the frame boundary
    xact_evt = NX'(1); step("R2 hidden");
    chk("R2 pending not visible", 32'(status_xact), 0);
    step("R2 idle");
    frame_wb_done = 1'b1; step("R2 boundary");
    chk("R2 visible after boundary", 32'(status_xact), 1);
    // R8: latched but masked
    step("R8 masked");
    chk("R8 masked irq", 32'(irq), 0);
    // R9: enable write takes one more edge to reach irq
    en_we = 1'b1; en_wdata = '1; step("R9 write");
    chk("R9 irq not yet", 32'(irq), 0);
    step("R9 after");
    chk("R9 irq after enable", 32'(irq), 1);
    // R3: coincident event belongs to the next frame
    xact_evt = NX'(2); frame_wb_done = 1'b1; step("R3 coincide");
    chk("R3 not in this frame", 32'(status_xact), 1);
    frame_wb_done = 1'b1; step("R3 next");
    chk("R3 in next frame", 32'(status_xact), 3);
    // R5: partial clear
    clr_we = 1'b1; clr_xact = NX'(2); step("R5 partial");
    chk("R5 partial clear", 32'(status_xact), 1);
    chk("R7 irq held", 32'(irq), 1);
    // R6: set beats clear
    xact_evt = NX'(1); step("R6 prep");
    frame_wb_done = 1'b1; clr_we = 1'b1; clr_xact = NX'(1); step("R6 collide");
    chk("R6 set wins", 32'(status_xact), 1);
    clr_we = 1'b1; clr_xact = '1; step("R7 clear all");
    chk("R5 all cleared", 32'(status_xact), 0);
    step("R7 fall");
    chk("R7 irq released", 32'(irq), 0);
    // R4/R8: errors ignore a zero enable
    en_we = 1'b1; en_wdata = '0; step("R8 disable");
    err_evt = NE'(1); step("R4 err");
    chk("R4 err set at once", 32'(status_err), 1);
    step("R4 irq");
    chk("R8 err unmasked irq", 32'(irq), 1);
    clr_we = 1'b1; clr_err = NE'(1); step("R5 err clear");
    step("R7 err fall");
    chk("R7 irq low after err clear", 32'(irq), 0);

    // Random phase
    for (int i = 0; i < 2000; i++) begin
      xact_evt      = (($urandom % 4) == 0) ? NX'($urandom) : '0;
      err_evt       = (($urandom % 16) == 0) ? NE'($urandom) : '0;
      frame_wb_done = (($urandom % 6) == 0);
      en_we         = (($urandom % 12) == 0);
      en_wdata      = NX'($urandom);
      clr_we        = (($urandom % 4) == 0);
      clr_xact      = NX'($urandom);
      clr_err       = NE'($urandom);
      step("rand");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule